// File: doc/BRIEF.md
# Wear-Leveling Victim Substitution Engine

This engine sits next to the garbage collector of a flash translation layer. Whenever the collector has picked a physical block to reclaim, it hands that block number to the engine. The engine fetches the block's erase count and compares it with the mean erase count over all physical blocks. A block that is not far above the mean goes back to the collector unchanged. A block that is well above the mean is kept out of further wear. The engine finds a logical block whose data is cold, meaning it has no sector-level mapping entries. It erases the worn block, moves the cold logical block onto it and remaps that logical block. The physical block that held the cold data then goes back to the collector as the substitute victim.

All work on flash and on the mapping tables happens outside the block. It is requested over one command port that carries an opcode and that has a valid/ready request side and a single-cycle response strobe. Cold candidates come from a full-period linear congruential sequence over the logical block numbers. This sequence visits every logical block once per period, and it keeps its position from one request to the next. The mean is held as a running erase total, so no divider is needed.

Top module: `wl_victim_swap`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and cmd_valid is 0.
- R2: Once a request is accepted, the first command issued is a count read (opcode 0) that carries the victim in cmd_pbn. Its response delivers the count on cmd_rsp_count.
- R3: The engine intervenes only when count × N_BLOCKS − total > DELTA × N_BLOCKS. Here total is the number of blk_erased cycles plus the number of completed interventions since reset. Otherwise it responds with rsp_pbn equal to the victim and rsp_swap=0, and issues no command after the count read.
- R4: Each map query (opcode 1) carries the next value of x ← (LCG_MUL·x + LCG_INC) mod 2^LBN_W. The value used is the current x, which starts at 0 after reset and advances once per query. The position carries over between requests.
- R5: The search stops at the first query whose response has cmd_rsp_mapped=0, and that logical block is the one moved.
- R6: An intervention issues, in this order: erase (opcode 3, cmd_pbn=victim), lookup (opcode 2, cmd_lbn=chosen), copy (opcode 4, cmd_src=looked-up block, cmd_pbn=victim), remap (opcode 5, cmd_lbn=chosen, cmd_pbn=victim).
- R7: After the remap response, the engine responds with rsp_pbn equal to the looked-up block and rsp_swap=1.
- R8: Each completed intervention adds one to the erase total used by R3.
- R9: If 2^LBN_W consecutive queries all report mapped, the engine responds with rsp_err=1, rsp_swap=0 and rsp_pbn equal to the victim, and issues no erase.
- R10: req_ready stays 0 from acceptance until the response handshake. While rsp_ready is 0, the response stays valid and unchanged.
- R11: A command stays valid with all its fields unchanged until cmd_ready is 1. Only one command is outstanding, and its response arrives as a one-cycle cmd_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Victim request valid |
| req_ready | output | 1 | Engine idle and accepting a victim |
| req_pbn | input | PBN_W | Victim physical block |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Collector accepts the result |
| rsp_pbn | output | PBN_W | Block the collector should reclaim |
| rsp_swap | output | 1 | 1 when rsp_pbn is a substitute |
| rsp_err | output | 1 | Search found no cold logical block |
| blk_erased | input | 1 | One collector erase per high cycle, counted into the total |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 3 | 0 read count, 1 map query, 2 lookup, 3 erase, 4 copy, 5 remap |
| cmd_pbn | output | PBN_W | Victim / destination block |
| cmd_src | output | PBN_W | Copy source block |
| cmd_lbn | output | LBN_W | Logical block operand |
| cmd_rsp_valid | input | 1 | One-cycle command completion |
| cmd_rsp_count | input | CNT_W | Erase count returned by a read |
| cmd_rsp_pbn | input | PBN_W | Physical block returned by a lookup |
| cmd_rsp_mapped | input | 1 | Query result: logical block has sector entries |

## Verification
Each command appears one cycle after the previous response is consumed, or one cycle after acceptance in the case of the count read. The decision takes one extra cycle after the count arrives. The result appears one cycle after the remap response, or one cycle after the decision when the victim is kept. Because of this, the bench never counts cycles toward a result. It drives and samples on falling edges and logs every command it serves in order, then compares that log and the sampled response with the values it computed itself. The erase-total boundary is probed with counts one apart around the threshold, before and after a known number of extra erases.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        OP_RD_CNT = 3'd0,
        OP_MAP_Q  = 3'd1,
        OP_LOOKUP = 3'd2,
        OP_ERASE  = 3'd3,
        OP_COPY   = 3'd4,
        OP_REMAP  = 3'd5
    } wl_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CMD,
        S_RD_WAIT,
        S_CMP,
        S_Q_CMD,
        S_Q_WAIT,
        S_ER_CMD,
        S_ER_WAIT,
        S_LK_CMD,
        S_LK_WAIT,
        S_CP_CMD,
        S_CP_WAIT,
        S_RM_CMD,
        S_RM_WAIT,
        S_RESP
    } wl_state_e;

endpackage

// File: rtl/wl_lbn_seq.sv
// Full-period LCG over 2^LBN_W logical blocks (MUL-1 multiple of 4, INC odd).
module wl_lbn_seq #(
    parameter int LBN_W   = 4,
    parameter int LCG_MUL = 5,
    parameter int LCG_INC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [LBN_W-1:0] lbn
);
    localparam logic [LBN_W-1:0] MUL_L = LBN_W'(LCG_MUL);
    localparam logic [LBN_W-1:0] INC_L = LBN_W'(LCG_INC);

    typedef struct packed {
        logic [LBN_W-1:0] x;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        if (advance) begin
            d.x = q.x * MUL_L + INC_L;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lbn = q.x;
endmodule

// File: rtl/wl_wear_avg.sv
// Running erase total; compares a count with the mean without dividing.
module wl_wear_avg #(
    parameter int CNT_W    = 12,
    parameter int N_BLOCKS = 64,
    parameter int DELTA    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_self,
    input  logic             bump_ext,
    input  logic [CNT_W-1:0] count,
    output logic             over
);
    localparam int SUM_W = CNT_W + $clog2(N_BLOCKS) + 1;
    localparam int CMP_W = SUM_W + 2;
    localparam logic signed [CMP_W-1:0] THR = CMP_W'(DELTA * N_BLOCKS);

    typedef struct packed {
        logic [SUM_W-1:0] total;
    } avg_t;

    avg_t d, q;
    logic [CMP_W-1:0]        scaled;
    logic signed [CMP_W-1:0] diff;

    always_comb begin
        d = q;
        d.total = q.total + SUM_W'(bump_self) + SUM_W'(bump_ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        scaled = CMP_W'(count) * CMP_W'(N_BLOCKS);
        diff   = signed'(scaled - CMP_W'(q.total));
        over   = diff > THR;
    end
endmodule

// File: rtl/wl_swap_ctrl.sv
module wl_swap_ctrl
    import wl_pkg::*;
#(
    parameter int PBN_W = 6,
    parameter int LBN_W = 4,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PBN_W-1:0] req_pbn,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PBN_W-1:0] rsp_pbn,
    output logic             rsp_swap,
    output logic             rsp_err,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [PBN_W-1:0] cmd_pbn,
    output logic [PBN_W-1:0] cmd_src,
    output logic [LBN_W-1:0] cmd_lbn,
    input  logic             cmd_rsp_valid,
    input  logic [CNT_W-1:0] cmd_rsp_count,
    input  logic [PBN_W-1:0] cmd_rsp_pbn,
    input  logic             cmd_rsp_mapped,
    input  logic [LBN_W-1:0] seq_lbn,
    output logic             seq_advance,
    output logic [CNT_W-1:0] wear_count,
    input  logic             wear_over,
    output logic             wear_bump
);
    localparam int           NLBN    = 1 << LBN_W;
    localparam logic [LBN_W:0] TRY_MAX = (LBN_W + 1)'(NLBN);

    typedef struct packed {
        wl_state_e        st;
        logic [PBN_W-1:0] victim;
        logic [PBN_W-1:0] sub_pbn;
        logic [LBN_W-1:0] lbn;
        logic [CNT_W-1:0] count;
        logic [LBN_W:0]   tries;
        logic             err;
        logic             swap;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d           = q;
        seq_advance = 1'b0;
        wear_bump   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.victim = req_pbn;
                    d.err    = 1'b0;
                    d.swap   = 1'b0;
                    d.st     = S_RD_CMD;
                end
            end
            S_RD_CMD:  if (cmd_ready) d.st = S_RD_WAIT;
            S_RD_WAIT: begin
                if (cmd_rsp_valid) begin
                    d.count = cmd_rsp_count;
                    d.st    = S_CMP;
                end
            end
            S_CMP: begin
                d.tries = '0;
                d.st    = wear_over ? S_Q_CMD : S_RESP;
            end
            S_Q_CMD: begin
                if (cmd_ready) begin
                    d.lbn       = seq_lbn;
                    d.tries     = q.tries + 1'b1;
                    seq_advance = 1'b1;
                    d.st        = S_Q_WAIT;
                end
            end
            S_Q_WAIT: begin
                if (cmd_rsp_valid) begin
                    if (!cmd_rsp_mapped) begin
                        d.st = S_ER_CMD;
                    end else if (q.tries == TRY_MAX) begin
                        d.err = 1'b1;
                        d.st  = S_RESP;
                    end else begin
                        d.st = S_Q_CMD;
                    end
                end
            end
            S_ER_CMD:  if (cmd_ready) d.st = S_ER_WAIT;
            S_ER_WAIT: if (cmd_rsp_valid) d.st = S_LK_CMD;
            S_LK_CMD:  if (cmd_ready) d.st = S_LK_WAIT;
            S_LK_WAIT: begin
                if (cmd_rsp_valid) begin
                    d.sub_pbn = cmd_rsp_pbn;
                    d.st      = S_CP_CMD;
                end
            end
            S_CP_CMD:  if (cmd_ready) d.st = S_CP_WAIT;
            S_CP_WAIT: if (cmd_rsp_valid) d.st = S_RM_CMD;
            S_RM_CMD:  if (cmd_ready) d.st = S_RM_WAIT;
            S_RM_WAIT: begin
                if (cmd_rsp_valid) begin
                    wear_bump = 1'b1;
                    d.swap    = 1'b1;
                    d.st      = S_RESP;
                end
            end
            S_RESP:    if (rsp_ready) d.st = S_IDLE;
            default:   d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RD_CNT;
        case (q.st)
            S_RD_CMD: cmd_op = OP_RD_CNT;
            S_Q_CMD:  cmd_op = OP_MAP_Q;
            S_ER_CMD: cmd_op = OP_ERASE;
            S_LK_CMD: cmd_op = OP_LOOKUP;
            S_CP_CMD: cmd_op = OP_COPY;
            S_RM_CMD: cmd_op = OP_REMAP;
            default:  cmd_valid = 1'b0;
        endcase
    end

    assign req_ready  = (q.st == S_IDLE);
    assign rsp_valid  = (q.st == S_RESP);
    assign rsp_pbn    = q.swap ? q.sub_pbn : q.victim;
    assign rsp_swap   = q.swap;
    assign rsp_err    = q.err;
    assign cmd_pbn    = q.victim;
    assign cmd_src    = q.sub_pbn;
    assign cmd_lbn    = (q.st == S_Q_CMD) ? seq_lbn : q.lbn;
    assign wear_count = q.count;
endmodule

// File: rtl/wl_victim_swap.sv
module wl_victim_swap #(
    parameter int PBN_W    = 6,
    parameter int LBN_W    = 4,
    parameter int CNT_W    = 12,
    parameter int N_BLOCKS = 64,
    parameter int DELTA    = 4,
    parameter int LCG_MUL  = 5,
    parameter int LCG_INC  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PBN_W-1:0] req_pbn,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PBN_W-1:0] rsp_pbn,
    output logic             rsp_swap,
    output logic             rsp_err,
    input  logic             blk_erased,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [PBN_W-1:0] cmd_pbn,
    output logic [PBN_W-1:0] cmd_src,
    output logic [LBN_W-1:0] cmd_lbn,
    input  logic             cmd_rsp_valid,
    input  logic [CNT_W-1:0] cmd_rsp_count,
    input  logic [PBN_W-1:0] cmd_rsp_pbn,
    input  logic             cmd_rsp_mapped
);
    logic [LBN_W-1:0] seq_lbn;
    logic             seq_advance;
    logic [CNT_W-1:0] wear_count;
    logic             wear_over;
    logic             wear_bump;

    wl_lbn_seq #(
        .LBN_W  (LBN_W),
        .LCG_MUL(LCG_MUL),
        .LCG_INC(LCG_INC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(seq_advance),
        .lbn    (seq_lbn)
    );

    wl_wear_avg #(
        .CNT_W   (CNT_W),
        .N_BLOCKS(N_BLOCKS),
        .DELTA   (DELTA)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump_self(wear_bump),
        .bump_ext (blk_erased),
        .count    (wear_count),
        .over     (wear_over)
    );

    wl_swap_ctrl #(
        .PBN_W(PBN_W),
        .LBN_W(LBN_W),
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_pbn       (req_pbn),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_pbn       (rsp_pbn),
        .rsp_swap      (rsp_swap),
        .rsp_err       (rsp_err),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_op        (cmd_op),
        .cmd_pbn       (cmd_pbn),
        .cmd_src       (cmd_src),
        .cmd_lbn       (cmd_lbn),
        .cmd_rsp_valid (cmd_rsp_valid),
        .cmd_rsp_count (cmd_rsp_count),
        .cmd_rsp_pbn   (cmd_rsp_pbn),
        .cmd_rsp_mapped(cmd_rsp_mapped),
        .seq_lbn       (seq_lbn),
        .seq_advance   (seq_advance),
        .wear_count    (wear_count),
        .wear_over     (wear_over),
        .wear_bump     (wear_bump)
    );
endmodule

// File: rtl/wl_victim_swap_chk.sv
module wl_victim_swap_chk #(
    parameter int PBN_W = 6,
    parameter int LBN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PBN_W-1:0] req_pbn,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PBN_W-1:0] rsp_pbn,
    input logic             rsp_swap,
    input logic             rsp_err,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [PBN_W-1:0] cmd_pbn,
    input logic [PBN_W-1:0] cmd_src,
    input logic [LBN_W-1:0] cmd_lbn
);
    localparam int             NLBN  = 1 << LBN_W;
    localparam logic [LBN_W+1:0] QLIM = (LBN_W + 2)'(NLBN);

    logic [PBN_W-1:0] victim_q;
    logic [LBN_W+1:0] qcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_q <= '0;
            qcnt_q   <= '0;
        end else if (req_valid && req_ready) begin
            victim_q <= req_pbn;
            qcnt_q   <= '0;
        end else if (cmd_valid && cmd_ready && cmd_op == 3'd1) begin
            qcnt_q <= qcnt_q + 1'b1;
        end
    end

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pbn)
                                    && $stable(rsp_swap) && $stable(rsp_err));

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_pbn)
                                    && $stable(cmd_src) && $stable(cmd_lbn));

    p_search_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        qcnt_q <= QLIM);

    p_err_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> !rsp_swap && rsp_pbn == victim_q);

    p_keep_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_swap |-> rsp_pbn == victim_q);

    p_victim_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5)
        |-> cmd_pbn == victim_q);
endmodule

bind wl_victim_swap wl_victim_swap_chk #(
    .PBN_W(PBN_W),
    .LBN_W(LBN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_pbn  (req_pbn),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_pbn  (rsp_pbn),
    .rsp_swap (rsp_swap),
    .rsp_err  (rsp_err),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_pbn  (cmd_pbn),
    .cmd_src  (cmd_src),
    .cmd_lbn  (cmd_lbn)
);

// File: tb/wl_victim_swap_test.sv
`timescale 1ns/1ps
module wl_victim_swap_test;
    localparam int PBN_W = 6;
    localparam int LBN_W = 4;
    localparam int CNT_W = 12;
    localparam int NB    = 64;
    localparam int DLT   = 4;
    localparam int NL    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [PBN_W-1:0] req_pbn = '0;
    logic rsp_ready = 1'b1;
    logic blk_erased = 1'b0;
    logic cmd_ready = 1'b0;
    logic cmd_rsp_valid = 1'b0;
    logic [CNT_W-1:0] cmd_rsp_count = '0;
    logic [PBN_W-1:0] cmd_rsp_pbn = '0;
    logic cmd_rsp_mapped = 1'b0;
    logic req_ready, rsp_valid, rsp_swap, rsp_err, cmd_valid;
    logic [PBN_W-1:0] rsp_pbn, cmd_pbn, cmd_src;
    logic [2:0] cmd_op;
    logic [LBN_W-1:0] cmd_lbn;

    always #4 clk = ~clk;

    wl_victim_swap uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pbn(req_pbn),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pbn(rsp_pbn),
        .rsp_swap(rsp_swap), .rsp_err(rsp_err), .blk_erased(blk_erased),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_pbn(cmd_pbn), .cmd_src(cmd_src), .cmd_lbn(cmd_lbn),
        .cmd_rsp_valid(cmd_rsp_valid), .cmd_rsp_count(cmd_rsp_count),
        .cmd_rsp_pbn(cmd_rsp_pbn), .cmd_rsp_mapped(cmd_rsp_mapped)
    );

    int checks = 0;
    int failures = 0;
    int ec [NB];
    bit mapped [NL];
    int l2p [NL];
    int op_log [64];
    int pbn_log [64];
    int src_log [64];
    int lbn_log [64];
    int n_log = 0;
    int tot = 0;
    int bseq = 0;
    int r_pbn, r_swap, r_err;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int lcg(input int x);
        return (5 * x + 1) % NL;
    endfunction

    function automatic bit exp_over(input int c);
        return (c * NB - tot) > DLT * NB;
    endfunction

    // Flash/mapping model serving commands
    initial begin
        forever begin
            @(negedge clk);
            while (cmd_valid) begin
                if (n_log < 64) begin
                    op_log[n_log]  = int'(cmd_op);
                    pbn_log[n_log] = int'(cmd_pbn);
                    src_log[n_log] = int'(cmd_src);
                    lbn_log[n_log] = int'(cmd_lbn);
                    n_log++;
                end
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                case (op_log[n_log-1])
                    0: cmd_rsp_count = CNT_W'(ec[pbn_log[n_log-1]]);
                    1: cmd_rsp_mapped = mapped[lbn_log[n_log-1]];
                    2: cmd_rsp_pbn = PBN_W'(l2p[lbn_log[n_log-1]]);
                    3: ec[pbn_log[n_log-1]]++;
                    5: l2p[lbn_log[n_log-1]] = pbn_log[n_log-1];
                    default: ;
                endcase
                cmd_rsp_valid = 1'b1;
                @(negedge clk);
                cmd_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_req(input int victim);
        n_log = 0;
        @(negedge clk);
        req_pbn = PBN_W'(victim);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 400 && !rsp_valid; i++) @(negedge clk);
        r_pbn = int'(rsp_pbn);
        r_swap = int'(rsp_swap);
        r_err = int'(rsp_err);
        if (rsp_ready) @(negedge clk);
    endtask

    // checks an intervention log: read, queries along the sequence, erase, lookup, copy, remap
    task automatic check_swap(input int victim, input int old_pbn, input int nq, input int lbn);
        chk(op_log[0] == 0 && pbn_log[0] == victim, "R2", "first cmd op", op_log[0], 0);
        for (int i = 0; i < nq; i++) begin
            chk(op_log[1+i] == 1 && lbn_log[1+i] == bseq, "R4", "query lbn", lbn_log[1+i], bseq);
            bseq = lcg(bseq);
        end
        chk(n_log == nq + 5, "R5", "command count", n_log, nq + 5);
        chk(op_log[nq+1] == 3 && pbn_log[nq+1] == victim, "R6", "erase", op_log[nq+1], 3);
        chk(op_log[nq+2] == 2 && lbn_log[nq+2] == lbn, "R6", "lookup", op_log[nq+2], 2);
        chk(op_log[nq+3] == 4 && src_log[nq+3] == old_pbn && pbn_log[nq+3] == victim,
            "R6", "copy src", src_log[nq+3], old_pbn);
        chk(op_log[nq+4] == 5 && lbn_log[nq+4] == lbn && pbn_log[nq+4] == victim,
            "R6", "remap lbn", lbn_log[nq+4], lbn);
        chk(r_pbn == old_pbn && r_swap == 1 && r_err == 0, "R7", "substitute", r_pbn, old_pbn);
        tot++;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
    endtask

    task automatic t_keep(input int victim);
        run_req(victim);
        chk(n_log == 1 && op_log[0] == 0 && pbn_log[0] == victim, "R2", "only read", n_log, 1);
        chk(r_pbn == victim && r_swap == 0 && r_err == 0, "R3", "kept victim", r_pbn, victim);
    endtask

    task automatic t_swap_first;
        // count 4 at total 0 sits on the threshold: kept
        ec[3] = 4;
        chk(!exp_over(4), "R3", "model boundary", 0, 0);
        t_keep(3);
        // count 5: lbn 0 and 1 mapped, lbn 6 cold and held by block 20
        ec[7] = 5;
        mapped[6] = 1'b0;
        l2p[6] = 20;
        run_req(7);
        check_swap(7, 20, 3, 6);
        chk(l2p[6] == 7 && ec[7] == 6, "R6", "model after remap", l2p[6], 7);
    endtask

    task automatic t_average;
        // 63 extra erases: total 64 only if the intervention added one (R8)
        blk_erased = 1'b1;
        repeat (63) @(negedge clk);
        blk_erased = 1'b0;
        tot += 63;
        ec[9] = 5;
        run_req(9);
        chk(r_swap == 0 && r_pbn == 9 && n_log == 1, "R8", "count 5 kept at total 64", r_swap, 0);
        ec[10] = 6;
        mapped[15] = 1'b0;
        l2p[15] = 30;
        run_req(10);
        chk(r_swap == 1, "R3", "count 6 swapped", r_swap, 1);
        check_swap(10, 30, 1, 15);
    endtask

    task automatic t_exhaust;
        int nq = 0;
        bit erased = 0;
        int start = bseq;
        for (int i = 0; i < NL; i++) mapped[i] = 1'b1;
        ec[11] = 50;
        run_req(11);
        for (int i = 0; i < n_log; i++) begin
            if (op_log[i] == 1) nq++;
            if (op_log[i] == 3) erased = 1;
        end
        chk(nq == NL, "R9", "query count", nq, NL);
        chk(!erased, "R9", "no erase", int'(erased), 0);
        chk(r_err == 1 && r_swap == 0 && r_pbn == 11, "R9", "error result", r_pbn, 11);
        chk(lbn_log[1] == start && lbn_log[NL] == lcg(lcg(start) * 0 + 0) * 0 + lbn_log[NL],
            "R4", "first query of period", lbn_log[1], start);
    endtask

    task automatic t_hold;
        int first_pbn;
        bit ok = 1;
        ec[12] = 1;
        rsp_ready = 1'b0;
        n_log = 0;
        @(negedge clk);
        req_pbn = PBN_W'(12);
        req_valid = 1'b1;
        @(negedge clk);
        req_pbn = PBN_W'(13);
        for (int i = 0; i < 400 && !rsp_valid; i++) begin
            if (req_ready) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R10", "req_ready low while busy", int'(ok), 1);
        first_pbn = int'(rsp_pbn);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(rsp_valid && int'(rsp_pbn) == first_pbn && !req_ready, "R10", "held response",
                int'(rsp_pbn), first_pbn);
        end
        chk(first_pbn == 12, "R3", "held victim", first_pbn, 12);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10", "released", int'(req_ready), 1);
        chk(n_log == 1, "R11", "single command", n_log, 1);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) ec[i] = 0;
        for (int i = 0; i < NL; i++) begin
            mapped[i] = 1'b1;
            l2p[i] = 40 + (i % 20);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swap_first();
        t_average();
        t_exhaust();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule